// File: doc/BRIEF.md
# Dual-Pixel Depth and Stencil Test Unit

This unit decides, for up to two pixels per clock, whether each pixel survives the depth and stencil tests. Each pixel carries a store address (its flattened screen position), a 32-bit IEEE float depth, a slot flag and a flag saying whether its shader may rewrite depth. The unit reads the depth and stencil fields held for that address in a small on-chip store. It checks the stored depth against a programmable inclusive window `[cfg_zmin, cfg_zmax]`, then runs a stencil test and a depth test. It updates the two fields independently and reports pass or kill one clock later.

The same unit serves both test points of the pipe. In the pre-shade slot (`px_late = 0`) a pixel whose shader may change depth is tested but leaves the store untouched. The post-shade slot (`px_late = 1`) repeats the test and performs the write, so early rejection stays available for every pixel. When both lanes of one cycle hit the same address, lane 1 is evaluated against the values lane 0 has just produced.

After reset a two-state controller clears the store before any pixel is accepted. In state `ST_CLEAR` it writes one entry per clock: depth becomes the clear value and stencil becomes zero. Its only transition, `CLEAR_DONE`, is taken when the last entry has been written and leads to `ST_RUN`. The controller then stays in `ST_RUN` until the next reset.

Top module: `zs_dual_tester`

## Requirements
- R1: After reset the unit holds `rdy` low while it clears every entry to depth `CLEAR_Z` (default 0x3F800000, 1.0) and stencil 0. `rdy` rises after the ENTRIES-th rising clock edge following reset release. While `rdy` is low, pixels are ignored and `res_valid` stays low.
- R2: A pixel on lane g that is accepted (`px_valid[g]` with `rdy` high) gives `res_valid[g]=1` and its verdict on `res_pass[g]` on the next clock. Lanes that are not accepted give `res_valid[g]=0`.
- R3: The depth test evaluates F(incoming, stored) with unsigned 32-bit ordering. Function codes are: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always.
- R4: If the stored depth lies outside the inclusive window `[cfg_zmin, cfg_zmax]` (unsigned), the pixel is killed and neither field of the store is written.
- R5: With `cfg_s_en=1` the stencil test evaluates F(`cfg_sref` & `cfg_srmask`, stored & `cfg_srmask`) with the R3 codes. With `cfg_s_en=0` the stencil test passes and the stencil field is never written. A pixel passes only if the range, stencil and depth tests all pass.
- R6: The stencil operation is `cfg_op_sfail` if the stencil test fails, `cfg_op_zfail` if the stencil test passes but the depth test fails, and `cfg_op_zpass` otherwise. Operation codes are: 0 keep, 1 zero, 2 replace with reference, 3 increment saturating at 255, 4 decrement saturating at 0, 5 bitwise invert; 6 and 7 act as keep. Only bits set in `cfg_swmask` change.
- R7: The incoming depth is written when the stencil and depth tests pass, `cfg_zwrite=1` and writing is allowed.
- R8: Writing is allowed in the post-shade slot, and in the pre-shade slot only when `px_shz=0`. A pre-shade pixel with `px_shz=1` is tested but writes neither field.
- R9: When both lanes target one address in the same cycle, lane 1 sees lane 0's updated depth and stencil. Where both lanes write a field, lane 1's value is the one kept.
- R10: Two pixels at distinct addresses are tested in the same cycle independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdy | output | 1 | Store cleared, pixels accepted |
| cfg_zfunc | input | 3 | Depth compare function code |
| cfg_zwrite | input | 1 | Depth write enable |
| cfg_zmin | input | 32 | Lower bound of the stored-depth window |
| cfg_zmax | input | 32 | Upper bound of the stored-depth window |
| cfg_s_en | input | 1 | Stencil test enable |
| cfg_sfunc | input | 3 | Stencil compare function code |
| cfg_sref | input | 8 | Stencil reference |
| cfg_srmask | input | 8 | Stencil compare mask |
| cfg_swmask | input | 8 | Stencil write mask |
| cfg_op_sfail | input | 3 | Operation on stencil fail |
| cfg_op_zfail | input | 3 | Operation on depth fail |
| cfg_op_zpass | input | 3 | Operation on full pass |
| px_valid | input | LANES | Pixel present per lane |
| px_addr | input | LANES*AW | Store address per lane |
| px_depth | input | LANES*32 | Incoming depth per lane |
| px_late | input | LANES | 1 = post-shade slot |
| px_shz | input | LANES | Shader may modify depth |
| res_valid | output | LANES | Verdict present per lane |
| res_pass | output | LANES | 1 = pass, 0 = kill |

## Verification
The assertions assume that configuration is held steady within a cycle and that depths are non-negative floats, so unsigned ordering matches numeric ordering. The stimulus only uses positive depth encodings and changes configuration only at the falling edge, between tests. They also assume that reset starts the clear sweep. The bench applies reset first, drives pixels during the sweep to confirm they are dropped, and confines random addresses to four entries so that same-cycle collisions between the lanes happen often.

// File: rtl/zs_pkg.sv
package zs_pkg;

    typedef enum logic [2:0] {
        CMP_NEVER  = 3'd0,
        CMP_LT     = 3'd1,
        CMP_EQ     = 3'd2,
        CMP_LE     = 3'd3,
        CMP_GT     = 3'd4,
        CMP_NE     = 3'd5,
        CMP_GE     = 3'd6,
        CMP_ALWAYS = 3'd7
    } cmp_e;

    typedef enum logic [2:0] {
        SOP_KEEP = 3'd0,
        SOP_ZERO = 3'd1,
        SOP_REPL = 3'd2,
        SOP_INCS = 3'd3,
        SOP_DECS = 3'd4,
        SOP_INV  = 3'd5,
        SOP_RSV6 = 3'd6,
        SOP_RSV7 = 3'd7
    } sop_e;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } fill_state_e;

    // Unsigned ordering; for non-negative IEEE floats this is numeric order.
    function automatic logic cmp_eval(input logic [2:0] fn,
                                      input logic [31:0] a,
                                      input logic [31:0] b);
        logic r;
        unique case (cmp_e'(fn))
            CMP_NEVER:  r = 1'b0;
            CMP_LT:     r = (a <  b);
            CMP_EQ:     r = (a == b);
            CMP_LE:     r = (a <= b);
            CMP_GT:     r = (a >  b);
            CMP_NE:     r = (a != b);
            CMP_GE:     r = (a >= b);
            CMP_ALWAYS: r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] sop_eval(input logic [2:0] op,
                                            input logic [7:0] cur,
                                            input logic [7:0] refv);
        logic [7:0] r;
        unique case (sop_e'(op))
            SOP_ZERO: r = 8'h00;
            SOP_REPL: r = refv;
            SOP_INCS: r = (cur == 8'hFF) ? cur : cur + 8'd1;
            SOP_DECS: r = (cur == 8'h00) ? cur : cur - 8'd1;
            SOP_INV:  r = ~cur;
            default:  r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/zs_fill_fsm.sv
module zs_fill_fsm #(
    parameter int ENTRIES = 16,
    parameter int AW      = 4
) (
    input  logic          clk,
    input  logic          rst,
    output logic          clr_en,
    output logic [AW-1:0] clr_addr,
    output logic          rdy
);
    import zs_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(ENTRIES - 1);

    fill_state_e state_q, state_d;
    logic [AW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR) cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state: CLEAR_DONE once the last entry is written
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (cnt_q == LAST) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        clr_en   = 1'b0;
        rdy      = 1'b0;
        clr_addr = cnt_q;
        unique case (state_q)
            ST_CLEAR: clr_en = 1'b1;
            ST_RUN:   rdy    = 1'b1;
        endcase
    end

    // R1: once running, the unit never returns to clearing without reset
    p_run_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));

endmodule

// File: rtl/zs_store.sv
module zs_store #(
    parameter int          ENTRIES = 16,
    parameter int          AW      = 4,
    parameter int          LANES   = 2,
    parameter int          ZW      = 32,
    parameter int          SW      = 8,
    parameter logic [31:0] CLEAR_Z = 32'h3F80_0000
) (
    input  logic          clk,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_addr,
    input  logic [AW-1:0] addr   [LANES],
    input  logic          we_z   [LANES],
    input  logic          we_s   [LANES],
    input  logic [ZW-1:0] wd_z   [LANES],
    input  logic [SW-1:0] wd_s   [LANES],
    output logic [ZW-1:0] rd_z   [LANES],
    output logic [SW-1:0] rd_s   [LANES]
);
    logic [ZW-1:0] mem_z [ENTRIES];
    logic [SW-1:0] mem_s [ENTRIES];

    // Higher lane index is written last and so takes precedence (R9).
    always_ff @(posedge clk) begin
        if (clr_en) begin
            mem_z[clr_addr] <= ZW'(CLEAR_Z);
            mem_s[clr_addr] <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (we_z[l]) mem_z[addr[l]] <= wd_z[l];
                if (we_s[l]) mem_s[addr[l]] <= wd_s[l];
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rd
        assign rd_z[g] = mem_z[addr[g]];
        assign rd_s[g] = mem_s[addr[g]];

        // R1: the clear sweep never coincides with a pixel write
        p_clr_excl_r1: assert property (@(posedge clk)
            clr_en |-> !(we_z[g] || we_s[g]));
    end

endmodule

// File: rtl/zs_lane_eval.sv
module zs_lane_eval #(
    parameter int ZW = 32,
    parameter int SW = 8
) (
    input  logic          valid,
    input  logic          late,
    input  logic          shz,
    input  logic [ZW-1:0] depth,
    input  logic [ZW-1:0] seen_z,
    input  logic [SW-1:0] seen_s,
    input  logic [2:0]    zfunc,
    input  logic          zwrite,
    input  logic [ZW-1:0] zmin,
    input  logic [ZW-1:0] zmax,
    input  logic          s_en,
    input  logic [2:0]    sfunc,
    input  logic [SW-1:0] sref,
    input  logic [SW-1:0] srmask,
    input  logic [SW-1:0] swmask,
    input  logic [2:0]    op_sfail,
    input  logic [2:0]    op_zfail,
    input  logic [2:0]    op_zpass,
    output logic          pass,
    output logic          range_ok,
    output logic          wr_z,
    output logic          wr_s,
    output logic [SW-1:0] new_s
);
    import zs_pkg::*;

    logic          s_ok, z_ok, may_wr;
    logic [2:0]    op_sel;
    logic [SW-1:0] op_res;

    always_comb begin
        range_ok = (seen_z >= zmin) && (seen_z <= zmax);
        s_ok     = !s_en || cmp_eval(sfunc, 32'(sref & srmask), 32'(seen_s & srmask));
        z_ok     = cmp_eval(zfunc, 32'(depth), 32'(seen_z));
        may_wr   = valid && range_ok && (late || !shz);
        pass     = valid && range_ok && s_ok && z_ok;

        if (!s_ok)      op_sel = op_sfail;
        else if (!z_ok) op_sel = op_zfail;
        else            op_sel = op_zpass;

        op_res = SW'(sop_eval(op_sel, 8'(seen_s), 8'(sref)));
        new_s  = (seen_s & ~swmask) | (op_res & swmask);
        wr_s   = may_wr && s_en;
        wr_z   = may_wr && s_ok && z_ok && zwrite;
    end

endmodule

// File: rtl/zs_dual_tester.sv
module zs_dual_tester #(
    parameter int          LANES   = 2,
    parameter int          AW      = 4,
    parameter logic [31:0] CLEAR_Z = 32'h3F80_0000
) (
    input  logic                clk,
    input  logic                rst,
    output logic                rdy,
    input  logic [2:0]          cfg_zfunc,
    input  logic                cfg_zwrite,
    input  logic [31:0]         cfg_zmin,
    input  logic [31:0]         cfg_zmax,
    input  logic                cfg_s_en,
    input  logic [2:0]          cfg_sfunc,
    input  logic [7:0]          cfg_sref,
    input  logic [7:0]          cfg_srmask,
    input  logic [7:0]          cfg_swmask,
    input  logic [2:0]          cfg_op_sfail,
    input  logic [2:0]          cfg_op_zfail,
    input  logic [2:0]          cfg_op_zpass,
    input  logic [LANES-1:0]    px_valid,
    input  logic [LANES*AW-1:0] px_addr,
    input  logic [LANES*32-1:0] px_depth,
    input  logic [LANES-1:0]    px_late,
    input  logic [LANES-1:0]    px_shz,
    output logic [LANES-1:0]    res_valid,
    output logic [LANES-1:0]    res_pass
);
    import zs_pkg::*;

    localparam int ENTRIES = 1 << AW;
    localparam int ZW      = 32;
    localparam int SW      = 8;

    logic          clr_en;
    logic [AW-1:0] clr_addr;

    logic [AW-1:0] l_addr  [LANES];
    logic [ZW-1:0] l_depth [LANES];
    logic [ZW-1:0] st_z    [LANES];
    logic [SW-1:0] st_s    [LANES];
    logic [ZW-1:0] seen_z  [LANES];
    logic [SW-1:0] seen_s  [LANES];
    logic [SW-1:0] new_s   [LANES];
    logic          we_z    [LANES];
    logic          we_s    [LANES];
    logic [LANES-1:0] acc, l_pass, l_rok, l_wz, l_ws;

    zs_fill_fsm #(.ENTRIES(ENTRIES), .AW(AW)) u_fill (
        .clk(clk), .rst(rst), .clr_en(clr_en), .clr_addr(clr_addr), .rdy(rdy)
    );

    zs_store #(.ENTRIES(ENTRIES), .AW(AW), .LANES(LANES), .ZW(ZW), .SW(SW),
               .CLEAR_Z(CLEAR_Z)) u_store (
        .clk(clk), .clr_en(clr_en), .clr_addr(clr_addr),
        .addr(l_addr), .we_z(we_z), .we_s(we_s), .wd_z(l_depth), .wd_s(new_s),
        .rd_z(st_z), .rd_s(st_s)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign l_addr[g]  = px_addr[g*AW +: AW];
        assign l_depth[g] = px_depth[g*ZW +: ZW];
        assign acc[g]     = px_valid[g] && rdy;
        assign we_z[g]    = l_wz[g];
        assign we_s[g]    = l_ws[g];

        // Forward the newest result of any lower lane at the same address.
        always_comb begin
            seen_z[g] = st_z[g];
            seen_s[g] = st_s[g];
            for (int j = 0; j < g; j++) begin
                if (l_addr[j] == l_addr[g]) begin
                    if (l_wz[j]) seen_z[g] = l_depth[j];
                    if (l_ws[j]) seen_s[g] = new_s[j];
                end
            end
        end

        zs_lane_eval #(.ZW(ZW), .SW(SW)) u_eval (
            .valid(acc[g]), .late(px_late[g]), .shz(px_shz[g]),
            .depth(l_depth[g]), .seen_z(seen_z[g]), .seen_s(seen_s[g]),
            .zfunc(cfg_zfunc), .zwrite(cfg_zwrite),
            .zmin(cfg_zmin), .zmax(cfg_zmax),
            .s_en(cfg_s_en), .sfunc(cfg_sfunc), .sref(cfg_sref),
            .srmask(cfg_srmask), .swmask(cfg_swmask),
            .op_sfail(cfg_op_sfail), .op_zfail(cfg_op_zfail), .op_zpass(cfg_op_zpass),
            .pass(l_pass[g]), .range_ok(l_rok[g]),
            .wr_z(l_wz[g]), .wr_s(l_ws[g]), .new_s(new_s[g])
        );

        // R4: an out-of-window stored depth is never reported as a pass
        p_range_kill_r4: assert property (@(posedge clk) disable iff (rst)
            (acc[g] && !l_rok[g]) |=> !res_pass[g]);

        // R4: an out-of-window pixel touches neither field
        p_range_nowr_r4: assert property (@(posedge clk) disable iff (rst)
            (acc[g] && !l_rok[g]) |-> !(we_z[g] || we_s[g]));

        // R8: a pre-shade pixel with shader depth never writes
        p_early_hold_r8: assert property (@(posedge clk) disable iff (rst)
            (acc[g] && !px_late[g] && px_shz[g]) |-> !(we_z[g] || we_s[g]));

        // R3: the never function kills every pixel
        p_never_kills_r3: assert property (@(posedge clk) disable iff (rst)
            (acc[g] && cfg_zfunc == 3'd0) |=> !res_pass[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= '0;
            res_pass  <= '0;
        end else begin
            res_valid <= acc;
            res_pass  <= l_pass;
        end
    end

    // R1: nothing is reported for a cycle in which the unit was not ready
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !rdy |=> (res_valid == '0));

endmodule

// File: tb/zs_dual_tester_tb.sv
module zs_dual_tester_tb_top;

    localparam int AW = 4;
    localparam int N  = 1 << AW;
    localparam logic [31:0] F1_0  = 32'h3F80_0000;
    localparam logic [31:0] F0_75 = 32'h3F40_0000;
    localparam logic [31:0] F0_5  = 32'h3F00_0000;
    localparam logic [31:0] F0_3  = 32'h3E99_999A;
    localparam logic [31:0] F0_25 = 32'h3E80_0000;
    localparam logic [31:0] FMAX  = 32'h7F7F_FFFF;

    logic clk = 1'b0;
    logic rst;
    logic rdy;
    logic [2:0] cfg_zfunc, cfg_sfunc, cfg_op_sfail, cfg_op_zfail, cfg_op_zpass;
    logic cfg_zwrite, cfg_s_en;
    logic [31:0] cfg_zmin, cfg_zmax;
    logic [7:0] cfg_sref, cfg_srmask, cfg_swmask;
    logic [1:0] px_valid, px_late, px_shz, res_valid, res_pass;
    logic [2*AW-1:0] px_addr;
    logic [63:0] px_depth;

    int vectors = 0;
    int miscompares = 0;

    logic [31:0] m_z [N];
    logic [7:0]  m_s [N];

    always #10 clk = ~clk;

    zs_dual_tester #(.LANES(2), .AW(AW)) dut_i (
        .clk(clk), .rst(rst), .rdy(rdy),
        .cfg_zfunc(cfg_zfunc), .cfg_zwrite(cfg_zwrite),
        .cfg_zmin(cfg_zmin), .cfg_zmax(cfg_zmax),
        .cfg_s_en(cfg_s_en), .cfg_sfunc(cfg_sfunc), .cfg_sref(cfg_sref),
        .cfg_srmask(cfg_srmask), .cfg_swmask(cfg_swmask),
        .cfg_op_sfail(cfg_op_sfail), .cfg_op_zfail(cfg_op_zfail),
        .cfg_op_zpass(cfg_op_zpass),
        .px_valid(px_valid), .px_addr(px_addr), .px_depth(px_depth),
        .px_late(px_late), .px_shz(px_shz),
        .res_valid(res_valid), .res_pass(res_pass)
    );

    function automatic bit rel(input int fn, input longint a, input longint b);
        case (fn)
            1: return a < b;
            2: return a == b;
            3: return a <= b;
            4: return a > b;
            5: return a != b;
            6: return a >= b;
            7: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int stop(input int op, input int cur, input int refv);
        case (op)
            1: return 0;
            2: return refv;
            3: return (cur >= 255) ? 255 : cur + 1;
            4: return (cur <= 0) ? 0 : cur - 1;
            5: return 255 - cur;
            default: return cur;
        endcase
    endfunction

    // Behavioural model of one pixel: returns verdict and updates the model store.
    function automatic bit model_px(input int a, input logic [31:0] d, input bit late, input bit shz);
        longint sz;
        int ss, op, res, nv;
        bit sok, zok, wr;
        sz = longint'(m_z[a]);
        ss = int'(m_s[a]);
        if (sz < longint'(cfg_zmin) || sz > longint'(cfg_zmax)) return 1'b0;
        sok = !cfg_s_en || rel(int'(cfg_sfunc), longint'(cfg_sref & cfg_srmask),
                                longint'(m_s[a] & cfg_srmask));
        zok = rel(int'(cfg_zfunc), longint'(d), sz);
        wr  = late || !shz;
        op  = !sok ? int'(cfg_op_sfail) : (!zok ? int'(cfg_op_zfail) : int'(cfg_op_zpass));
        res = stop(op, ss, int'(cfg_sref));
        nv  = (ss & ~int'(cfg_swmask) & 255) | (res & int'(cfg_swmask));
        if (wr && cfg_s_en) m_s[a] = 8'(nv);
        if (wr && sok && zok && cfg_zwrite) m_z[a] = d;
        return sok && zok;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, check the verdict at the next falling edge.
    task automatic step(input string tag,
                        input bit v0, input int a0, input logic [31:0] d0, input bit l0, input bit s0,
                        input bit v1, input int a1, input logic [31:0] d1, input bit l1, input bit s1);
        bit e0, e1;
        px_valid = {v1, v0};
        px_addr  = {AW'(a1), AW'(a0)};
        px_depth = {d1, d0};
        px_late  = {l1, l0};
        px_shz   = {s1, s0};
        e0 = v0 ? model_px(a0, d0, l0, s0) : 1'b0;
        e1 = v1 ? model_px(a1, d1, l1, s1) : 1'b0;
        @(negedge clk);
        chk(tag, "lane0 valid", int'(res_valid[0]), int'(v0));
        chk(tag, "lane1 valid", int'(res_valid[1]), int'(v1));
        if (v0) chk(tag, "lane0 pass", int'(res_pass[0]), int'(e0));
        if (v1) chk(tag, "lane1 pass", int'(res_pass[1]), int'(e1));
        px_valid = 2'b00;
    endtask

    task automatic base_cfg();
        cfg_zfunc = 3'd1; cfg_zwrite = 1'b1; cfg_zmin = 32'h0; cfg_zmax = FMAX;
        cfg_s_en = 1'b0; cfg_sfunc = 3'd7; cfg_sref = 8'h00;
        cfg_srmask = 8'hFF; cfg_swmask = 8'hFF;
        cfg_op_sfail = 3'd0; cfg_op_zfail = 3'd0; cfg_op_zpass = 3'd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int n;
        base_cfg();
        px_valid = 2'b00; px_addr = '0; px_depth = '0; px_late = '0; px_shz = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "rdy in reset", int'(rdy), 0);
        chk("R2", "res_valid in reset", int'(res_valid), 0);
        rst = 1'b0;
        for (int i = 0; i < N; i++) begin m_z[i] = F1_0; m_s[i] = 8'h00; end

        // R1: pixels offered during the clear sweep are dropped
        px_valid = 2'b11; px_late = 2'b11; px_depth = {F0_25, F0_25};
        n = 0;
        @(negedge clk);
        while (!rdy && n < 4 * N) begin
            chk("R1", "res_valid while clearing", int'(res_valid), 0);
            n++;
            @(negedge clk);
        end
        chk("R1", "clear sweep length", n, N - 1);
        px_valid = 2'b00;
        @(negedge clk);

        // R1 clear values, R10 independent lanes
        cfg_zfunc = 3'd2; cfg_zwrite = 1'b0;
        step("R1", 1, 5, F1_0, 1, 0, 1, 9, F0_5, 1, 0);

        // R9 same-address forwarding, R7 depth write
        cfg_zfunc = 3'd1; cfg_zwrite = 1'b1;
        step("R9", 1, 3, F0_5, 1, 0, 1, 3, F0_75, 1, 0);
        step("R9", 1, 3, F0_25, 1, 0, 1, 3, F0_25, 1, 0);
        step("R7", 1, 4, F0_75, 1, 0, 1, 4, F0_5, 1, 0);

        // R3 function sweep, no writes
        cfg_zwrite = 1'b0;
        for (int f = 0; f < 8; f++) begin
            cfg_zfunc = 3'(f);
            step("R3", 1, 3, F0_25, 1, 0, 1, 4, F0_75, 1, 0);
            step("R3", 1, 3, F0_5, 1, 0, 1, 4, F0_25, 1, 0);
        end

        // R4 range reject with write attempted, then read back
        cfg_zwrite = 1'b1; cfg_zfunc = 3'd7; cfg_zmin = F0_3; cfg_zmax = F0_75;
        step("R4", 1, 3, F0_5, 1, 0, 1, 6, F0_5, 1, 0);
        step("R4", 1, 4, F0_25, 1, 0, 0, 0, F0_5, 1, 0);
        cfg_zmin = 32'h0; cfg_zmax = FMAX; cfg_zfunc = 3'd2; cfg_zwrite = 1'b0;
        step("R4", 1, 3, F0_25, 1, 0, 1, 6, F1_0, 1, 0);

        // R5 / R6 stencil
        cfg_s_en = 1'b1; cfg_sfunc = 3'd7; cfg_zfunc = 3'd7; cfg_op_zpass = 3'd3;
        step("R6", 1, 6, F1_0, 1, 0, 1, 6, F1_0, 1, 0);
        cfg_op_zpass = 3'd0; cfg_sfunc = 3'd2; cfg_sref = 8'd2;
        step("R5", 1, 6, F1_0, 1, 0, 1, 7, F1_0, 1, 0);
        cfg_zfunc = 3'd0; cfg_op_zfail = 3'd2; cfg_sfunc = 3'd7; cfg_sref = 8'hFF;
        step("R6", 1, 8, F1_0, 1, 0, 0, 0, F1_0, 1, 0);
        cfg_zfunc = 3'd7; cfg_op_zpass = 3'd3;
        step("R6", 1, 8, F1_0, 1, 0, 0, 0, F1_0, 1, 0);
        cfg_op_zpass = 3'd0; cfg_sfunc = 3'd2;
        step("R6", 1, 8, F1_0, 1, 0, 1, 9, F1_0, 1, 0);
        cfg_sfunc = 3'd7; cfg_op_zpass = 3'd4; cfg_sref = 8'h00;
        step("R6", 1, 9, F1_0, 1, 0, 0, 0, F1_0, 1, 0);
        cfg_op_zpass = 3'd5; cfg_swmask = 8'h0F;
        step("R6", 1, 9, F1_0, 1, 0, 0, 0, F1_0, 1, 0);
        cfg_swmask = 8'hFF; cfg_op_zpass = 3'd0; cfg_sfunc = 3'd2; cfg_sref = 8'h0F;
        step("R6", 1, 9, F1_0, 1, 0, 0, 0, F1_0, 1, 0);
        cfg_sfunc = 3'd0; cfg_op_sfail = 3'd1;
        step("R5", 1, 6, F1_0, 1, 0, 0, 0, F1_0, 1, 0);
        cfg_sfunc = 3'd2; cfg_sref = 8'd0; cfg_op_sfail = 3'd0;
        step("R5", 1, 6, F1_0, 1, 0, 0, 0, F1_0, 1, 0);
        cfg_s_en = 1'b0; cfg_sfunc = 3'd7; cfg_op_zpass = 3'd1;
        step("R5", 1, 8, F1_0, 1, 0, 0, 0, F1_0, 1, 0);
        cfg_s_en = 1'b1; cfg_sfunc = 3'd2; cfg_sref = 8'hFF; cfg_op_zpass = 3'd0;
        step("R5", 1, 8, F1_0, 1, 0, 0, 0, F1_0, 1, 0);
        cfg_s_en = 1'b0;

        // R8 pre-shade hold, then pre-shade and post-shade writes
        cfg_zfunc = 3'd1; cfg_zwrite = 1'b1;
        step("R8", 1, 10, F0_25, 0, 1, 1, 11, F0_5, 0, 0);
        cfg_zfunc = 3'd2; cfg_zwrite = 1'b0;
        step("R8", 1, 10, F1_0, 1, 0, 1, 11, F0_5, 1, 0);
        cfg_zfunc = 3'd1; cfg_zwrite = 1'b1;
        step("R8", 1, 10, F0_25, 1, 1, 0, 0, F1_0, 1, 0);
        cfg_zfunc = 3'd2; cfg_zwrite = 1'b0;
        step("R8", 1, 10, F0_25, 1, 0, 0, 0, F1_0, 1, 0);

        // R2 / R9 mixed random traffic on four addresses
        for (int c = 0; c < 3000; c++) begin
            logic [31:0] dset [4];
            dset[0] = F0_25; dset[1] = F0_5; dset[2] = F0_75; dset[3] = F1_0;
            if (c % 40 == 0) begin
                cfg_zfunc = 3'($urandom_range(7)); cfg_zwrite = 1'($urandom_range(1));
                cfg_s_en = 1'($urandom_range(1)); cfg_sfunc = 3'($urandom_range(7));
                cfg_sref = 8'($urandom_range(3)); cfg_srmask = ($urandom_range(1) != 0) ? 8'hFF : 8'h03;
                cfg_swmask = ($urandom_range(1) != 0) ? 8'hFF : 8'h0F;
                cfg_op_sfail = 3'($urandom_range(7)); cfg_op_zfail = 3'($urandom_range(7));
                cfg_op_zpass = 3'($urandom_range(7));
                cfg_zmin = ($urandom_range(3) == 0) ? F0_3 : 32'h0;
                cfg_zmax = ($urandom_range(3) == 0) ? F0_75 : FMAX;
            end
            step((c % 2 == 0) ? "R2" : "R9",
                 1'($urandom_range(1)), int'($urandom_range(3)), dset[$urandom_range(3)],
                 1'($urandom_range(1)), 1'($urandom_range(1)),
                 1'($urandom_range(1)), int'($urandom_range(3)), dset[$urandom_range(3)],
                 1'($urandom_range(1)), 1'($urandom_range(1)));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule